// File: doc/BRIEF.md
# DS3 Maintenance Signal Inserter

This block sits in the serial transmit path of a DS3 framer. It takes one line bit per clock, works out where that bit falls in the M-frame from its own position counters, and produces the bit to transmit. The counters restart whenever the M-frame start strobe is high. A two-bit mode input chooses the output. In normal mode user traffic and the user-owned overhead pass through unchanged. In alarm-indication mode and in idle mode all user payload is replaced by a fixed repeating pattern, and some overhead bits are forced to fixed values.

The block always generates the framing bits, the multiframe alignment bits and the parity bits itself, so the output frame stays well formed in every mode. The parity bits of each M-frame cover the payload that was actually sent in the previous M-frame, including any inserted pattern. A downstream parity check therefore stays clean while a maintenance signal is being sent. A mode request takes effect only at an M-frame boundary. Two flags, delayed together with the data, mark each output bit as payload or overhead.

An M-frame has 7 subframes. Each subframe has 8 blocks, and each block is one overhead bit followed by `PAYLOAD_BITS` payload bits. The DS3 format uses 84.

Top module: `ds3_maint_inserter`

## Requirements
- R1: A bit presented with `mf_start_i` high is the first overhead bit (block 1) of subframe 1. Counting from that bit, each block is 1 overhead bit followed by `PAYLOAD_BITS` payload bits, there are 8 blocks per subframe and 7 subframes per M-frame. After the last bit the count wraps to the first bit on its own. `ovhd_o` is high only for overhead bits and `payload_o` is high only for payload bits.
- R2: The overhead bits of blocks 2, 4, 6 and 8 in every subframe are output as 1, 0, 0, 1, in every mode and whatever the input.
- R3: The block 1 overhead bits of subframes 5, 6 and 7 are output as 0, 1, 0.
- R4: Mode codes: 2'b00 and 2'b11 are normal, 2'b01 is alarm indication (AIS) and 2'b10 is idle. In normal mode the payload bits, the block 1 overhead bits of subframes 1 and 2 (X-bits) and the block 3, 5 and 7 overhead bits (C-bits) pass through unchanged.
- R5: In AIS mode every C-bit is output as 0, both X-bits as 1, and the payload as the repeating sequence 1,0,1,0 starting with 1.
- R6: In idle mode the three C-bits of subframe 3 are output as 0 and the other C-bits pass through. Both X-bits are output as 1, and the payload is the repeating sequence 1,1,0,0 starting with 1.
- R7: The payload pattern steps only on payload bits and restarts at the first payload bit of each M-frame.
- R8: The mode is sampled only on the first bit of an M-frame and is held for the whole M-frame.
- R9: Both parity bits (block 1 overhead of subframes 3 and 4) equal the XOR of all payload bits output during the previous M-frame, so they are 1 for an odd count of ones. They are 0 in the first M-frame after reset.
- R10: `data_o`, `payload_o` and `ovhd_o` follow their input bit by one clock and are 0 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mf_start_i | input | 1 | High on the first bit of an M-frame |
| mode_i | input | 2 | 00/11 normal, 01 AIS, 10 idle |
| data_i | input | 1 | Incoming line bit |
| data_o | output | 1 | Outgoing line bit, one clock later |
| payload_o | output | 1 | `data_o` is a payload bit |
| ovhd_o | output | 1 | `data_o` is an overhead bit |

## Verification
The bench builds the block with `PAYLOAD_BITS` = 4, which makes an M-frame 280 bits long. Dozens of frame boundaries fit in a short run: mode handover at boundaries, mode requests changing mid-frame, realignment of the counters by the strobe, free-running wrap without a strobe, and parity carried from one frame to the next. The frame structure and every overhead position are the same as with the full 84-bit blocks. Only the payload length per block changes.

// File: rtl/ds3_maint_pkg.sv
package ds3_maint_pkg;

  localparam int SUBFRAMES = 7;
  localparam int BLOCKS    = 8;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_AIS    = 2'b01,
    MODE_IDLE   = 2'b10,
    MODE_SPARE  = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    SLOT_PAYLOAD = 3'd0,
    SLOT_XBIT    = 3'd1,
    SLOT_PBIT    = 3'd2,
    SLOT_FIXED   = 3'd3,
    SLOT_CBIT    = 3'd4
  } slot_kind_e;

  typedef struct packed {
    slot_kind_e kind;
    logic       fixed_val;  // value of framing / alignment slots
    logic       in_sub3;    // C-bit lying in subframe 3
  } slot_t;

  // Classify one bit from its subframe, block and overhead flag.
  function automatic slot_t decode_slot(input logic [2:0] sub,
                                        input logic [2:0] blk,
                                        input logic       is_ovhd);
    slot_t s;
    s.kind      = SLOT_PAYLOAD;
    s.fixed_val = 1'b0;
    s.in_sub3   = (sub == 3'd2);
    if (is_ovhd) begin
      case (blk)
        3'd0: begin
          if (sub < 3'd2)      s.kind = SLOT_XBIT;
          else if (sub < 3'd4) s.kind = SLOT_PBIT;
          else begin
            s.kind      = SLOT_FIXED;
            s.fixed_val = (sub == 3'd5);  // 0,1,0 over subframes 5..7
          end
        end
        3'd1, 3'd7: begin
          s.kind      = SLOT_FIXED;
          s.fixed_val = 1'b1;
        end
        3'd3, 3'd5: begin
          s.kind      = SLOT_FIXED;
          s.fixed_val = 1'b0;
        end
        default: s.kind = SLOT_CBIT;  // blocks 3, 5, 7
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/ds3_frame_pos.sv
module ds3_frame_pos
  import ds3_maint_pkg::*;
#(
  parameter int PAYLOAD_BITS = 84
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output logic [2:0] sub_o,
  output logic [2:0] blk_o,
  output logic       ovhd_o,
  output logic       frame_start_o
);

  localparam int             BW       = $clog2(PAYLOAD_BITS + 1);
  localparam logic [BW-1:0]  LAST_BIT = BW'(PAYLOAD_BITS);
  localparam logic [2:0]     LAST_SUB = 3'(SUBFRAMES - 1);
  localparam logic [2:0]     LAST_BLK = 3'(BLOCKS - 1);

  logic [2:0]    sub_q, sub_d, sub_cur;
  logic [2:0]    blk_q, blk_d, blk_cur;
  logic [BW-1:0] bit_q, bit_d, bit_cur;

  // Position of the bit presented in this cycle
  always_comb begin
    if (start_i) begin
      sub_cur = '0;
      blk_cur = '0;
      bit_cur = '0;
    end else begin
      sub_cur = sub_q;
      blk_cur = blk_q;
      bit_cur = bit_q;
    end
  end

  // Position of the following bit
  always_comb begin
    sub_d = sub_cur;
    blk_d = blk_cur;
    bit_d = bit_cur + 1'b1;
    if (bit_cur == LAST_BIT) begin
      bit_d = '0;
      if (blk_cur == LAST_BLK) begin
        blk_d = '0;
        sub_d = (sub_cur == LAST_SUB) ? 3'd0 : sub_cur + 3'd1;
      end else begin
        blk_d = blk_cur + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      blk_q <= '0;
      bit_q <= '0;
    end else begin
      sub_q <= sub_d;
      blk_q <= blk_d;
      bit_q <= bit_d;
    end
  end

  assign sub_o         = sub_cur;
  assign blk_o         = blk_cur;
  assign ovhd_o        = (bit_cur == '0);
  assign frame_start_o = (sub_cur == '0) && (blk_cur == '0) && (bit_cur == '0);

  // R1: stored position never leaves the frame
  p_pos_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_q <= LAST_SUB) && (blk_q <= LAST_BLK) && (bit_q <= LAST_BIT));

  // R1: the last bit of a frame is followed by the first one
  p_frame_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_cur == LAST_SUB && blk_cur == LAST_BLK && bit_cur == LAST_BIT)
      |=> (sub_q == '0 && blk_q == '0 && bit_q == '0));

endmodule

// File: rtl/ds3_pattern_gen.sv
module ds3_pattern_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start_i,
  input  logic payload_i,
  input  logic ais_i,
  output logic pat_bit_o
);

  logic [1:0] phase_q, phase_d, phase_cur;
  logic       phase_en;

  assign phase_cur = frame_start_i ? 2'd0 : phase_q;
  assign phase_en  = frame_start_i || payload_i;

  always_comb begin
    if (frame_start_i) phase_d = 2'd0;
    else               phase_d = phase_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= 2'd0;
    else if (phase_en) phase_q <= phase_d;
  end

  // AIS: 1,0,1,0   idle: 1,1,0,0
  assign pat_bit_o = ais_i ? ~phase_cur[0] : ~phase_cur[1];

  // R7: the phase restarts with every frame
  p_phase_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> (phase_q == 2'd0));

  // R7: overhead bits leave the phase untouched
  p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!payload_i && !frame_start_i) |=> $stable(phase_q));

endmodule

// File: rtl/ds3_parity_acc.sv
module ds3_parity_acc (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start_i,
  input  logic payload_i,
  input  logic tx_bit_i,
  output logic pbit_o
);

  logic acc_q, acc_d, acc_en;
  logic pbit_q;

  assign acc_en = frame_start_i || payload_i;

  always_comb begin
    if (frame_start_i) acc_d = 1'b0;
    else               acc_d = acc_q ^ tx_bit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= 1'b0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pbit_q <= 1'b0;
    else if (frame_start_i) pbit_q <= acc_q;
  end

  assign pbit_o = pbit_q;

  // R9: the accumulator is empty at the start of each frame
  p_acc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> (acc_q == 1'b0));

  // R9: the sent parity changes only at a frame boundary
  p_pbit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start_i |=> $stable(pbit_q));

endmodule

// File: rtl/ds3_maint_inserter.sv
module ds3_maint_inserter
  import ds3_maint_pkg::*;
#(
  parameter int PAYLOAD_BITS = 84
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mf_start_i,
  input  logic [1:0] mode_i,
  input  logic       data_i,
  output logic       data_o,
  output logic       payload_o,
  output logic       ovhd_o
);

  logic [2:0] sub_w, blk_w;
  logic       is_ovhd_w, frame_start_w;
  slot_t      slot_w;

  mode_e      mode_q, eff_mode;
  logic       maint_w, ais_w;
  logic       pat_bit_w, pbit_w;
  logic       out_d;
  logic       data_q, pay_q, ovh_q;

  ds3_frame_pos #(.PAYLOAD_BITS(PAYLOAD_BITS)) u_pos (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (mf_start_i),
    .sub_o         (sub_w),
    .blk_o         (blk_w),
    .ovhd_o        (is_ovhd_w),
    .frame_start_o (frame_start_w)
  );

  assign slot_w = decode_slot(sub_w, blk_w, is_ovhd_w);

  // Mode is taken only on the first bit of a frame
  assign eff_mode = frame_start_w ? mode_e'(mode_i) : mode_q;
  assign ais_w    = (eff_mode == MODE_AIS);
  assign maint_w  = (eff_mode == MODE_AIS) || (eff_mode == MODE_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             mode_q <= MODE_NORMAL;
    else if (frame_start_w) mode_q <= eff_mode;
  end

  ds3_pattern_gen u_pat (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start_w),
    .payload_i     (!is_ovhd_w),
    .ais_i         (ais_w),
    .pat_bit_o     (pat_bit_w)
  );

  ds3_parity_acc u_par (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start_w),
    .payload_i     (!is_ovhd_w),
    .tx_bit_i      (out_d),
    .pbit_o        (pbit_w)
  );

  // Output bit selection
  always_comb begin
    out_d = data_i;
    case (slot_w.kind)
      SLOT_PAYLOAD: out_d = maint_w ? pat_bit_w : data_i;
      SLOT_XBIT:    out_d = maint_w ? 1'b1 : data_i;
      SLOT_PBIT:    out_d = pbit_w;
      SLOT_FIXED:   out_d = slot_w.fixed_val;
      SLOT_CBIT: begin
        if (eff_mode == MODE_AIS)                         out_d = 1'b0;
        else if (eff_mode == MODE_IDLE && slot_w.in_sub3) out_d = 1'b0;
        else                                              out_d = data_i;
      end
      default:      out_d = data_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      pay_q  <= 1'b0;
      ovh_q  <= 1'b0;
    end else begin
      data_q <= out_d;
      pay_q  <= !is_ovhd_w;
      ovh_q  <= is_ovhd_w;
    end
  end

  assign data_o    = data_q;
  assign payload_o = pay_q;
  assign ovhd_o    = ovh_q;

  // R8: no mode change inside a frame
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start_w |=> $stable(mode_q));

  // R1: a bit is never marked as both payload and overhead
  p_slot_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(payload_o && ovhd_o));

  // R5: an AIS frame sends no C-bit as 1
  p_ais_cbit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_w.kind == SLOT_CBIT && eff_mode == MODE_AIS) |=> !data_o);

endmodule

// File: tb/ds3_maint_inserter_tb.sv
module ds3_maint_inserter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PL         = 4;
  localparam int FRAME_LEN  = 7 * 8 * (PL + 1);

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mf_start_i;
  logic [1:0] mode_i;
  logic       data_i;
  logic       data_o, payload_o, ovhd_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ds3_maint_inserter #(.PAYLOAD_BITS(PL)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mf_start_i (mf_start_i),
    .mode_i     (mode_i),
    .data_i     (data_i),
    .data_o     (data_o),
    .payload_o  (payload_o),
    .ovhd_o     (ovhd_o)
  );

  // Bench reference state
  int         m_sub, m_blk, m_bit;
  logic [1:0] m_mode, m_ph;
  logic       m_acc, m_p;
  logic       pend, e_data, e_pay, e_ovh;
  string      e_tag;
  string      scen;
  logic [15:0] lfsr;

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, scen, act, exp, $time);
    end
  endtask

  function automatic logic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic model_reset();
    m_sub = 0; m_blk = 0; m_bit = 0;
    m_mode = 2'b00; m_ph = 2'b00; m_acc = 1'b0; m_p = 1'b0;
    pend = 1'b0;
  endtask

  // One bit: compare the previous output, then drive a new input
  task automatic step(input logic d, input logic st, input logic [1:0] md);
    logic ais, idle, exp;
    string tag;
    @(negedge clk);
    if (pend) begin
      check(e_tag, data_o, e_data);
      check("R1 payload flag", payload_o, e_pay);
      check("R1 overhead flag", ovhd_o, e_ovh);
    end
    if (st) begin m_sub = 0; m_blk = 0; m_bit = 0; end
    if (m_sub == 0 && m_blk == 0 && m_bit == 0) begin
      m_mode = md; m_p = m_acc; m_acc = 1'b0; m_ph = 2'b00;
    end
    ais  = (m_mode == 2'b01);
    idle = (m_mode == 2'b10);
    if (m_bit != 0) begin
      if (ais)       begin exp = ~m_ph[0]; tag = "R5,R7 payload"; end
      else if (idle) begin exp = ~m_ph[1]; tag = "R6,R7 payload"; end
      else           begin exp = d;        tag = "R4 payload";    end
      m_acc = m_acc ^ exp;
      m_ph  = m_ph + 2'd1;
    end else begin
      case (m_blk)
        0: begin
          if (m_sub < 2) begin
            exp = (ais || idle) ? 1'b1 : d;
            tag = ais ? "R5 X-bit" : (idle ? "R6 X-bit" : "R4 X-bit");
          end else if (m_sub < 4) begin
            exp = m_p; tag = "R9 P-bit";
          end else begin
            exp = (m_sub == 5); tag = "R3 M-bit";
          end
        end
        1, 7: begin exp = 1'b1; tag = "R2 F-bit"; end
        3, 5: begin exp = 1'b0; tag = "R2 F-bit"; end
        default: begin
          if (ais)                     begin exp = 1'b0; tag = "R5 C-bit"; end
          else if (idle && m_sub == 2) begin exp = 1'b0; tag = "R6 C-bit"; end
          else begin exp = d; tag = idle ? "R6 C-bit" : "R4 C-bit"; end
        end
      endcase
    end
    e_data = exp; e_tag = tag;
    e_pay = (m_bit != 0); e_ovh = (m_bit == 0);
    // advance the reference position
    if (m_bit == PL) begin
      m_bit = 0;
      if (m_blk == 7) begin
        m_blk = 0;
        m_sub = (m_sub == 6) ? 0 : m_sub + 1;
      end else m_blk = m_blk + 1;
    end else m_bit = m_bit + 1;
    data_i = d; mf_start_i = st; mode_i = md; pend = 1'b1;
  endtask

  // Run n bits with the strobe on each frame start (when use_strobe)
  task automatic run_bits(input int n, input logic [1:0] md, input logic use_strobe,
                          input logic all_ones);
    for (int i = 0; i < n; i++) begin
      logic st;
      st = use_strobe && (m_sub == 0 && m_blk == 0 && m_bit == 0);
      step(all_ones ? 1'b1 : next_rand(), st, md);
    end
  endtask

  task automatic test_reset();  // R10
    scen = "reset";
    rst_n = 1'b0; mf_start_i = 1'b0; mode_i = 2'b00; data_i = 1'b1;
    model_reset();
    repeat (3) begin
      @(negedge clk);
      check("R10 data in reset", data_o, 1'b0);
      check("R10 payload flag in reset", payload_o, 1'b0);
      check("R10 overhead flag in reset", ovhd_o, 1'b0);
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic test_normal();  // R2 R3 R4 R9 R10
    scen = "normal";
    run_bits(2 * FRAME_LEN, 2'b00, 1'b1, 1'b0);
    scen = "spare code";
    run_bits(FRAME_LEN, 2'b11, 1'b1, 1'b0);
  endtask

  task automatic test_ais();  // R5 R7
    scen = "ais";
    run_bits(3 * FRAME_LEN, 2'b01, 1'b1, 1'b0);
  endtask

  task automatic test_idle();  // R6 R7
    scen = "idle";
    run_bits(3 * FRAME_LEN, 2'b10, 1'b1, 1'b0);
  endtask

  task automatic test_mode_switch();  // R8
    logic [1:0] md;
    scen = "R8 mid-frame mode change";
    md = 2'b01;
    for (int i = 0; i < 3 * FRAME_LEN; i++) begin
      if (i % 37 == 36) md = md + 2'd1;
      step(next_rand(), (m_sub == 0 && m_blk == 0 && m_bit == 0), md);
    end
  endtask

  task automatic test_realign();  // R1
    scen = "R1 realign";
    run_bits(123, 2'b10, 1'b0, 1'b0);
    step(next_rand(), 1'b1, 2'b01);
    run_bits(2 * FRAME_LEN, 2'b01, 1'b0, 1'b0);
    scen = "R1 free-run wrap";
    run_bits(2 * FRAME_LEN, 2'b00, 1'b0, 1'b0);
  endtask

  task automatic test_parity();  // R9
    scen = "R9 all ones";
    run_bits(2 * FRAME_LEN, 2'b00, 1'b1, 1'b1);
    scen = "R9 idle parity";
    run_bits(2 * FRAME_LEN, 2'b10, 1'b1, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog expired: got hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    lfsr = 16'hACE1;
    test_reset();
    test_normal();
    test_ais();
    test_idle();
    test_mode_switch();
    test_realign();
    test_parity();
    step(1'b0, 1'b0, 2'b00);  // flush the last expected bit
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule